// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home node for a group of cache lines under a point-to-point directory coherence protocol. For every line it holds a directory entry and the line's memory copy. The entry has a state (Uncached, Shared, Modified, or one of two transient busy states), the owner core and a one-bit-per-core sharer vector. Cores send it messages on one inbound valid/ready port: read, read-exclusive, writeback, invalidation acknowledge and forward acknowledge. The controller answers on one outbound valid/ready port with data fills, forwarded reads or recalls, invalidations and negative acknowledges. Each message goes only to the cores that the directory lists for the line.

Only one multi-message transaction is open at a time. Until it completes, every new read or read-exclusive is refused with a NACK, and the requester retries. A read to a dirty line follows one of two flows, chosen by a parameter. In the three-hop flow the owner supplies the requester directly. In the four-hop flow home recalls the line from the owner and supplies the requester itself. If a writeback from the owner crosses a pending forwarded read, home serves the read from the written-back data and settles the line in Shared, with no extra acknowledgement.

Top module: `hn_home_ctrl`

## Requirements
- R1: After reset no message is output, the inbound port is ready, every line is Uncached and every line's memory copy reads as zero.
- R2: A read to an Uncached or Shared line returns at once a data message (type 0) to the requester, carrying the memory copy. The requester is added to the sharers.
- R3: With FOUR_HOP=0, a read to a line Modified at another core sends a forward (type 1) to the owner, carrying the requester id. The owner's forward acknowledge (inbound type 4) writes its data to memory and leaves owner and requester as sharers. Home sends nothing further.
- R4: With FOUR_HOP=1, the same read sends a recall (type 4) to the owner. The owner's forward acknowledge writes memory, and home then sends a data message with that data to the requester. Both cores become sharers.
- R5: A read-exclusive (inbound type 1) sends one invalidation (type 2) to each current sharer other than the requester, lowest core index first. The data fill follows only after the same number of invalidation acknowledges (inbound type 3) arrive.
- R6: A read-exclusive to a line Modified at another core invalidates that owner. The data in the owner's acknowledge is written to memory and returned in the fill.
- R7: A read-exclusive with no other holder is filled at once, and the requester becomes sole owner in Modified.
- R8: A writeback (inbound type 2) from the owner of a Modified line writes memory and makes the line Uncached. A writeback from any other core changes nothing.
- R9: A writeback from the owner while a forwarded read for that line is pending sends a data message with the written-back data to the requester. The line becomes Shared with only the requester as sharer, and no acknowledge is awaited.
- R10: While a transaction is open, any read or read-exclusive receives a NACK (type 3) to the sender for that line, and the directory is left unchanged.
- R11: An output message is held with all fields stable while out_ready_i is low.
- R12: Invalidation or forward acknowledges that match no open transaction are dropped without effect on memory or directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Inbound message valid |
| in_ready_o | output | 1 | Inbound message accepted this cycle when valid |
| in_type_i | input | 3 | 0 read, 1 read-exclusive, 2 writeback, 3 invalidation ack, 4 forward ack |
| in_src_i | input | log2(NUM_CORES) | Sending core |
| in_line_i | input | log2(NUM_LINES) | Line index |
| in_data_i | input | DATA_W | Line data for writeback and acknowledges |
| out_valid_o | output | 1 | Outbound message valid |
| out_ready_i | input | 1 | Outbound message taken |
| out_type_o | output | 3 | 0 data, 1 forward, 2 invalidate, 3 NACK, 4 recall |
| out_dst_o | output | log2(NUM_CORES) | Destination core |
| out_line_o | output | log2(NUM_LINES) | Line index |
| out_req_o | output | log2(NUM_CORES) | Core that started the transaction |
| out_data_o | output | DATA_W | Line data for data messages, zero otherwise |

## Verification
Properties check the following on every cycle: held outputs stay stable; a refused request always yields a NACK; the ack counter never reaches zero while home is waiting for acks; exactly one invalidation target is picked while invalidations are being sent; a Modified entry never keeps sharers; the race writeback is answered with data. Other behaviours span many messages and can only be shown by the bench's scenarios. These are the order of invalidations, the fill being withheld until the last ack, data passing from owner to memory to later readers, the final sharer sets after forwarded and racing reads, and the difference between the three-hop and four-hop variants.

// File: rtl/hn_pkg.sv
package hn_pkg;
  typedef enum logic [2:0] {
    DS_UNC    = 3'd0,
    DS_SHR    = 3'd1,
    DS_MOD    = 3'd2,
    DS_BUSY_X = 3'd3,
    DS_BUSY_R = 3'd4
  } dir_st_e;

  typedef enum logic [2:0] {
    IM_RD     = 3'd0,
    IM_RDX    = 3'd1,
    IM_WB     = 3'd2,
    IM_INVACK = 3'd3,
    IM_FWDACK = 3'd4
  } in_msg_e;

  typedef enum logic [2:0] {
    OM_DATA   = 3'd0,
    OM_FWD    = 3'd1,
    OM_INV    = 3'd2,
    OM_NACK   = 3'd3,
    OM_RECALL = 3'd4
  } out_msg_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_SEND_INV,
    CS_WAIT_ACK,
    CS_WAIT_FWD
  } ctrl_st_e;
endpackage

// File: rtl/hn_pick_low.sv
module hn_pick_low #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hn_popcnt.sv
module hn_popcnt #(
  parameter int N = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/hn_dir_store.sv
module hn_dir_store
  import hn_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 16,
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = $clog2(NUM_CORES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LW-1:0]        rd_line_i,
  output dir_st_e              rd_state_o,
  output logic [CW-1:0]        rd_owner_o,
  output logic [NUM_CORES-1:0] rd_sharers_o,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic [LW-1:0]        wr_line_i,
  input  logic                 dir_we_i,
  input  dir_st_e              wr_state_i,
  input  logic [CW-1:0]        wr_owner_i,
  input  logic [NUM_CORES-1:0] wr_sharers_i,
  input  logic                 mem_we_i,
  input  logic [DATA_W-1:0]    mem_data_i
);
  dir_st_e              st_a  [NUM_LINES];
  logic [CW-1:0]        own_a [NUM_LINES];
  logic [NUM_CORES-1:0] shr_a [NUM_LINES];
  logic [DATA_W-1:0]    mem_a [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dir_st_e              st_q;
    logic [CW-1:0]        own_q;
    logic [NUM_CORES-1:0] shr_q;
    logic [DATA_W-1:0]    mem_q;
    logic                 hit;

    assign hit = (wr_line_i == LW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= DS_UNC;
        own_q <= '0;
        shr_q <= '0;
        mem_q <= '0;
      end else begin
        if (dir_we_i && hit) begin
          st_q  <= wr_state_i;
          own_q <= wr_owner_i;
          shr_q <= wr_sharers_i;
        end
        if (mem_we_i && hit) mem_q <= mem_data_i;
      end
    end

    assign st_a[g]  = st_q;
    assign own_a[g] = own_q;
    assign shr_a[g] = shr_q;
    assign mem_a[g] = mem_q;
  end

  assign rd_state_o   = st_a[rd_line_i];
  assign rd_owner_o   = own_a[rd_line_i];
  assign rd_sharers_o = shr_a[rd_line_i];
  assign rd_data_o    = mem_a[rd_line_i];

  // a Modified entry keeps a single owner and no clean copies
  assert_mod_no_sharer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && wr_state_i == DS_MOD |-> wr_sharers_i == '0);
endmodule

// File: rtl/hn_home_ctrl.sv
module hn_home_ctrl
  import hn_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 16,
  parameter bit FOUR_HOP  = 1'b0,
  localparam int CW   = $clog2(NUM_CORES),
  localparam int LW   = $clog2(NUM_LINES),
  localparam int CNTW = $clog2(NUM_CORES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        in_type_i,
  input  logic [CW-1:0]     in_src_i,
  input  logic [LW-1:0]     in_line_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [2:0]        out_type_o,
  output logic [CW-1:0]     out_dst_o,
  output logic [LW-1:0]     out_line_o,
  output logic [CW-1:0]     out_req_o,
  output logic [DATA_W-1:0] out_data_o
);
  function automatic logic [NUM_CORES-1:0] core_bit(input logic [CW-1:0] c);
    logic [NUM_CORES-1:0] b;
    b    = '0;
    b[c] = 1'b1;
    return b;
  endfunction

  ctrl_st_e             cs_q, cs_d;
  logic [LW-1:0]        t_line_q, t_line_d;
  logic [CW-1:0]        t_req_q, t_req_d, t_owner_q, t_owner_d;
  logic                 t_mod_q, t_mod_d;
  logic [NUM_CORES-1:0] inv_mask_q, inv_mask_d;
  logic [CNTW-1:0]      ack_cnt_q, ack_cnt_d;

  dir_st_e              rd_state;
  logic [CW-1:0]        rd_owner;
  logic [NUM_CORES-1:0] rd_sharers;
  logic [DATA_W-1:0]    rd_data;
  logic                 dir_we, mem_we;
  dir_st_e              wr_state;
  logic [CW-1:0]        wr_owner;
  logic [NUM_CORES-1:0] wr_sharers;

  logic                 out_free, fire, is_t_line;
  logic [NUM_CORES-1:0] src_bit, excl_mask, pick_oh;
  logic [CW-1:0]        pick_idx;
  logic [CNTW-1:0]      excl_cnt;
  out_msg_e             fwd_type;

  logic                 out_ld;
  out_msg_e             o_type;
  logic [CW-1:0]        o_dst, o_req;
  logic [LW-1:0]        o_line;
  logic [DATA_W-1:0]    o_data;

  assign out_free   = !out_valid_o || out_ready_i;
  assign in_ready_o = out_free && (cs_q != CS_SEND_INV);
  assign fire       = in_valid_i && in_ready_o;
  assign is_t_line  = (in_line_i == t_line_q);
  assign src_bit    = core_bit(in_src_i);
  assign excl_mask  = (rd_state == DS_MOD) ? (core_bit(rd_owner) & ~src_bit)
                                           : (rd_sharers & ~src_bit);

  if (FOUR_HOP) begin : g_recall
    assign fwd_type = OM_RECALL;
  end else begin : g_fwd
    assign fwd_type = OM_FWD;
  end

  hn_dir_store #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_line_i   (in_line_i),
    .rd_state_o  (rd_state),
    .rd_owner_o  (rd_owner),
    .rd_sharers_o(rd_sharers),
    .rd_data_o   (rd_data),
    .wr_line_i   (in_line_i),
    .dir_we_i    (dir_we),
    .wr_state_i  (wr_state),
    .wr_owner_i  (wr_owner),
    .wr_sharers_i(wr_sharers),
    .mem_we_i    (mem_we),
    .mem_data_i  (in_data_i)
  );

  hn_popcnt #(.N(NUM_CORES)) u_cnt (.vec_i(excl_mask), .cnt_o(excl_cnt));

  hn_pick_low #(.N(NUM_CORES)) u_pick (.mask_i(inv_mask_q), .onehot_o(pick_oh), .idx_o(pick_idx));

  always_comb begin
    cs_d       = cs_q;
    t_line_d   = t_line_q;
    t_req_d    = t_req_q;
    t_owner_d  = t_owner_q;
    t_mod_d    = t_mod_q;
    inv_mask_d = inv_mask_q;
    ack_cnt_d  = ack_cnt_q;
    out_ld     = 1'b0;
    o_type     = OM_DATA;
    o_dst      = in_src_i;
    o_line     = in_line_i;
    o_req      = in_src_i;
    o_data     = '0;
    dir_we     = 1'b0;
    mem_we     = 1'b0;
    wr_state   = rd_state;
    wr_owner   = rd_owner;
    wr_sharers = rd_sharers;

    if (cs_q == CS_SEND_INV && out_free) begin
      out_ld     = 1'b1;
      o_type     = OM_INV;
      o_dst      = pick_idx;
      o_line     = t_line_q;
      o_req      = t_req_q;
      inv_mask_d = inv_mask_q & ~pick_oh;
      if (inv_mask_d == '0) cs_d = CS_WAIT_ACK;
    end

    if (fire) begin
      unique case (in_msg_e'(in_type_i))
        IM_RD, IM_RDX: begin
          if (cs_q != CS_IDLE) begin
            out_ld = 1'b1;
            o_type = OM_NACK;
          end else if (in_msg_e'(in_type_i) == IM_RD) begin
            if (rd_state == DS_MOD && rd_owner != in_src_i) begin
              out_ld    = 1'b1;
              o_type    = fwd_type;
              o_dst     = rd_owner;
              dir_we    = 1'b1;
              wr_state  = DS_BUSY_R;
              t_line_d  = in_line_i;
              t_req_d   = in_src_i;
              t_owner_d = rd_owner;
              cs_d      = CS_WAIT_FWD;
            end else begin
              out_ld = 1'b1;
              o_data = rd_data;
              if (rd_state != DS_MOD) begin
                dir_we     = 1'b1;
                wr_state   = DS_SHR;
                wr_sharers = rd_sharers | src_bit;
              end
            end
          end else if (excl_cnt == '0) begin
            out_ld     = 1'b1;
            o_data     = rd_data;
            dir_we     = 1'b1;
            wr_state   = DS_MOD;
            wr_owner   = in_src_i;
            wr_sharers = '0;
          end else begin
            dir_we     = 1'b1;
            wr_state   = DS_BUSY_X;
            t_line_d   = in_line_i;
            t_req_d    = in_src_i;
            t_mod_d    = (rd_state == DS_MOD);
            inv_mask_d = excl_mask;
            ack_cnt_d  = excl_cnt;
            cs_d       = CS_SEND_INV;
          end
        end
        IM_WB: begin
          if (rd_state == DS_MOD && rd_owner == in_src_i) begin
            mem_we     = 1'b1;
            dir_we     = 1'b1;
            wr_state   = DS_UNC;
            wr_owner   = '0;
            wr_sharers = '0;
          end else if (cs_q == CS_WAIT_FWD && is_t_line && in_src_i == t_owner_q) begin
            // writeback crossed the forwarded read: serve it from home
            mem_we     = 1'b1;
            out_ld     = 1'b1;
            o_dst      = t_req_q;
            o_req      = t_req_q;
            o_data     = in_data_i;
            dir_we     = 1'b1;
            wr_state   = DS_SHR;
            wr_owner   = '0;
            wr_sharers = core_bit(t_req_q);
            cs_d       = CS_IDLE;
          end
        end
        IM_INVACK: begin
          if (cs_q == CS_WAIT_ACK && is_t_line) begin
            ack_cnt_d = ack_cnt_q - 1'b1;
            mem_we    = t_mod_q;
            if (ack_cnt_q == CNTW'(1)) begin
              out_ld     = 1'b1;
              o_dst      = t_req_q;
              o_req      = t_req_q;
              o_data     = t_mod_q ? in_data_i : rd_data;
              dir_we     = 1'b1;
              wr_state   = DS_MOD;
              wr_owner   = t_req_q;
              wr_sharers = '0;
              cs_d       = CS_IDLE;
            end
          end
        end
        IM_FWDACK: begin
          if (cs_q == CS_WAIT_FWD && is_t_line && in_src_i == t_owner_q) begin
            mem_we     = 1'b1;
            dir_we     = 1'b1;
            wr_state   = DS_SHR;
            wr_owner   = '0;
            wr_sharers = core_bit(t_owner_q) | core_bit(t_req_q);
            cs_d       = CS_IDLE;
            if (FOUR_HOP) begin
              out_ld = 1'b1;
              o_dst  = t_req_q;
              o_req  = t_req_q;
              o_data = in_data_i;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= CS_IDLE;
      t_line_q   <= '0;
      t_req_q    <= '0;
      t_owner_q  <= '0;
      t_mod_q    <= 1'b0;
      inv_mask_q <= '0;
      ack_cnt_q  <= '0;
    end else begin
      cs_q       <= cs_d;
      t_line_q   <= t_line_d;
      t_req_q    <= t_req_d;
      t_owner_q  <= t_owner_d;
      t_mod_q    <= t_mod_d;
      inv_mask_q <= inv_mask_d;
      ack_cnt_q  <= ack_cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_type_o  <= '0;
      out_dst_o   <= '0;
      out_line_o  <= '0;
      out_req_o   <= '0;
      out_data_o  <= '0;
    end else if (out_ld) begin
      out_valid_o <= 1'b1;
      out_type_o  <= o_type;
      out_dst_o   <= o_dst;
      out_line_o  <= o_line;
      out_req_o   <= o_req;
      out_data_o  <= o_data;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  assert_out_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_type_o) && $stable(out_dst_o)
      && $stable(out_line_o) && $stable(out_req_o) && $stable(out_data_o));

  assert_busy_nack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cs_q != CS_IDLE && (in_type_i == 3'd0 || in_type_i == 3'd1)
      |=> out_valid_o && out_type_o == 3'(OM_NACK) && out_dst_o == $past(in_src_i));

  assert_ack_cnt_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q == CS_WAIT_ACK |-> ack_cnt_q != '0);

  assert_inv_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q == CS_SEND_INV |-> $onehot(pick_oh));

  assert_fwd_line_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q == CS_WAIT_FWD && fire && is_t_line |-> rd_state == DS_BUSY_R);

  assert_race_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cs_q == CS_WAIT_FWD && in_type_i == 3'd2 && is_t_line && in_src_i == t_owner_q
      |=> out_valid_o && out_type_o == 3'(OM_DATA) && out_dst_o == $past(t_req_q)
          && out_data_o == $past(in_data_i));
endmodule

// File: tb/hn_home_ctrl_tb.sv
module hn_home_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam int LW = 3;
  localparam int MW = 3 + CW + LW + CW + DW;

  localparam logic [2:0] T_RD = 3'd0, T_RDX = 3'd1, T_WB = 3'd2, T_IACK = 3'd3, T_FACK = 3'd4;
  localparam logic [2:0] O_DATA = 3'd0, O_FWD = 3'd1, O_INV = 3'd2, O_NACK = 3'd3, O_RECALL = 3'd4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [2:0]    in_type = '0;
  logic [CW-1:0] in_src = '0;
  logic [LW-1:0] in_line = '0;
  logic [DW-1:0] in_data = '0;
  logic v_a = 1'b0, v_b = 1'b0, oready = 1'b1;
  logic rdy_a, rdy_b, ov_a, ov_b;
  logic [2:0] ot_a, ot_b;
  logic [CW-1:0] od_a, od_b, oq_a, oq_b;
  logic [LW-1:0] ol_a, ol_b;
  logic [DW-1:0] odt_a, odt_b;

  hn_home_ctrl #(.NUM_CORES(NC), .NUM_LINES(NL), .DATA_W(DW), .FOUR_HOP(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v_a), .in_ready_o(rdy_a), .in_type_i(in_type),
    .in_src_i(in_src), .in_line_i(in_line), .in_data_i(in_data), .out_valid_o(ov_a),
    .out_ready_i(oready), .out_type_o(ot_a), .out_dst_o(od_a), .out_line_o(ol_a),
    .out_req_o(oq_a), .out_data_o(odt_a));

  hn_home_ctrl #(.NUM_CORES(NC), .NUM_LINES(NL), .DATA_W(DW), .FOUR_HOP(1'b1)) u_dut_rc (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v_b), .in_ready_o(rdy_b), .in_type_i(in_type),
    .in_src_i(in_src), .in_line_i(in_line), .in_data_i(in_data), .out_valid_o(ov_b),
    .out_ready_i(oready), .out_type_o(ot_b), .out_dst_o(od_b), .out_line_o(ol_b),
    .out_req_o(oq_b), .out_data_o(odt_b));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [MW-1:0] exp_a[$], exp_b[$];
  string tag_a[$], tag_b[$];

  task automatic chk(input bit ok, input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_msg(input bit rc, input logic [2:0] t, input int dst, input int line,
                            input int req, input logic [DW-1:0] d, input string tag);
    logic [MW-1:0] m;
    m = {t, dst[CW-1:0], line[LW-1:0], req[CW-1:0], d};
    if (rc) begin exp_b.push_back(m); tag_b.push_back(tag); end
    else    begin exp_a.push_back(m); tag_a.push_back(tag); end
  endtask

  task automatic compare(input bit rc, input logic [MW-1:0] act);
    logic [MW-1:0] e;
    string t;
    if ((rc ? exp_b.size() : exp_a.size()) == 0) begin
      chk(1'b0, "unexpected message (R10/R12)", act, '0);
    end else begin
      if (rc) begin e = exp_b.pop_front(); t = tag_b.pop_front(); end
      else    begin e = exp_a.pop_front(); t = tag_a.pop_front(); end
      chk(act == e, t, act, e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (ov_a && oready) compare(1'b0, {ot_a, od_a, ol_a, oq_a, odt_a});
      if (ov_b && oready) compare(1'b1, {ot_b, od_b, ol_b, oq_b, odt_b});
    end
  end

  task automatic send(input bit rc, input logic [2:0] t, input int src, input int line,
                      input logic [DW-1:0] d);
    @(negedge clk);
    in_type = t;
    in_src  = src[CW-1:0];
    in_line = line[LW-1:0];
    in_data = d;
    if (rc) v_b = 1'b1; else v_a = 1'b1;
    while (!(rc ? rdy_b : rdy_a)) @(negedge clk);
    @(posedge clk);
    #1;
    v_a = 1'b0;
    v_b = 1'b0;
  endtask

  task automatic drained(input string tag);
    repeat (6) @(negedge clk);
    chk(exp_a.size() == 0 && exp_b.size() == 0 && !ov_a && !ov_b, tag,
        MW'(exp_a.size() + exp_b.size()), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] snap, cur;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!ov_a && rdy_a && !ov_b && rdy_b, "R1 reset outputs", {ov_a, rdy_a}, MW'(1));

    // R1 / R2: reads of an Uncached then Shared line
    expect_msg(0, O_DATA, 0, 0, 0, 16'h0, "R1 memory zero after reset");
    send(0, T_RD, 0, 0, '0);
    expect_msg(0, O_DATA, 1, 0, 1, 16'h0, "R2 read of shared line");
    send(0, T_RD, 1, 0, '0);
    drained("R2 direct replies only");

    // R5 / R10: exclusive request invalidates sharers 0 and 1
    expect_msg(0, O_INV, 0, 0, 2, 16'h0, "R5 invalidate lowest sharer first");
    expect_msg(0, O_INV, 1, 0, 2, 16'h0, "R5 invalidate second sharer");
    send(0, T_RDX, 2, 0, '0);
    expect_msg(0, O_NACK, 3, 0, 3, 16'h0, "R10 nack same line while pending");
    send(0, T_RD, 3, 0, '0);
    expect_msg(0, O_NACK, 3, 5, 3, 16'h0, "R10 nack other line while pending");
    send(0, T_RDX, 3, 5, '0);
    send(0, T_IACK, 1, 0, '0);
    drained("R5 fill withheld until last ack");
    expect_msg(0, O_DATA, 2, 0, 2, 16'h0, "R5 fill after all acks");
    send(0, T_IACK, 0, 0, '0);
    drained("R5 single fill");

    // R3: three-hop forwarded read from owner 2
    expect_msg(0, O_FWD, 2, 0, 3, 16'h0, "R3 forward to owner (R10 nack left entry intact)");
    send(0, T_RD, 3, 0, '0);
    send(0, T_FACK, 2, 0, 16'h1234);
    drained("R3 no home reply in three-hop flow");
    expect_msg(0, O_DATA, 0, 0, 0, 16'h1234, "R3 owner data written to memory");
    send(0, T_RD, 0, 0, '0);

    // R7 / R6: exclusive on Uncached, then on remote Modified
    expect_msg(0, O_DATA, 1, 1, 1, 16'h0, "R7 immediate exclusive fill");
    send(0, T_RDX, 1, 1, '0);
    expect_msg(0, O_INV, 1, 1, 3, 16'h0, "R6 invalidate remote owner");
    send(0, T_RDX, 3, 1, '0);
    expect_msg(0, O_DATA, 3, 1, 3, 16'h00AB, "R6 fill carries owner data");
    send(0, T_IACK, 1, 1, 16'h00AB);

    // R8: owner writeback, then stale writeback from a non-owner
    send(0, T_WB, 3, 1, 16'h5555);
    send(0, T_WB, 0, 1, 16'h7777);
    drained("R8 writebacks are silent");
    expect_msg(0, O_DATA, 2, 1, 2, 16'h5555, "R8 owner data kept, non-owner ignored");
    send(0, T_RD, 2, 1, '0);

    // R9: writeback races a forwarded read
    expect_msg(0, O_DATA, 0, 2, 0, 16'h0, "R7 exclusive fill line 2");
    send(0, T_RDX, 0, 2, '0);
    expect_msg(0, O_FWD, 0, 2, 1, 16'h0, "R9 forward before race");
    send(0, T_RD, 1, 2, '0);
    expect_msg(0, O_DATA, 1, 2, 1, 16'h0BAD, "R9 home serves racing read");
    send(0, T_WB, 0, 2, 16'h0BAD);
    expect_msg(0, O_INV, 1, 2, 2, 16'h0, "R9 only requester left as sharer");
    send(0, T_RDX, 2, 2, '0);
    expect_msg(0, O_DATA, 2, 2, 2, 16'h0BAD, "R9 memory holds writeback data");
    send(0, T_IACK, 1, 2, '0);

    // R12: stray acknowledges
    send(0, T_IACK, 3, 3, 16'hFFFF);
    send(0, T_FACK, 3, 3, 16'hFFFF);
    drained("R12 stray acks produce nothing");
    expect_msg(0, O_DATA, 3, 3, 3, 16'h0, "R12 memory and state untouched");
    send(0, T_RD, 3, 3, '0);
    drained("R12 read not refused");

    // R11: backpressure holds the message
    @(posedge clk); #1 oready = 1'b0;
    expect_msg(0, O_DATA, 0, 4, 0, 16'h0, "R11 held message delivered");
    send(0, T_RD, 0, 4, '0);
    snap = {ot_a, od_a, ol_a, oq_a, odt_a};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cur = {ot_a, od_a, ol_a, oq_a, odt_a};
      chk(ov_a && cur == snap, "R11 stable while stalled", cur, snap);
    end
    @(posedge clk); #1 oready = 1'b1;
    drained("R11 released");

    // R4: four-hop recall flow on the second instance
    expect_msg(1, O_DATA, 0, 0, 0, 16'h0, "R4 setup exclusive");
    send(1, T_RDX, 0, 0, '0);
    expect_msg(1, O_RECALL, 0, 0, 1, 16'h0, "R4 recall to owner");
    send(1, T_RD, 1, 0, '0);
    expect_msg(1, O_DATA, 1, 0, 1, 16'h4242, "R4 home replies after recall");
    send(1, T_FACK, 0, 0, 16'h4242);
    expect_msg(1, O_INV, 0, 0, 2, 16'h0, "R4 old owner kept as sharer");
    expect_msg(1, O_INV, 1, 0, 2, 16'h0, "R4 requester kept as sharer");
    send(1, T_RDX, 2, 0, '0);
    send(1, T_IACK, 0, 0, '0);
    expect_msg(1, O_DATA, 2, 0, 2, 16'h4242, "R4 recalled data in memory");
    send(1, T_IACK, 1, 0, '0);
    drained("R4 flow complete");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule